// File: doc/BRIEF.md
# Legacy Index/Data Register Window Decoder

This block gives software access to the internal 8-bit registers of a two-socket controller through a legacy pair of I/O ports. The first port of the pair holds an index byte and the second moves one data byte. Four consecutive I/O addresses start at a programmable, 4-byte aligned base. The even addresses (base+0, base+2) are index ports. Each odd address (base+1, base+3) is the data port of the pair below it.

Each socket holds a 3-bit socket number in a 32-bit configuration register. The upper bit of the number chooses which port pair the socket answers on. The lower two bits choose which 64-entry quarter of the index space it owns. A data-port access goes to the socket that matches both the port pair and the top two bits of that pair's latched index. The low six index bits are passed on as the register offset. The register file itself sits outside the block and is reached through a per-socket select, a write strobe, an offset and the data buses.

Top module: `legacy_io_window`

## Requirements
- R1: The socket-number register of each socket is read and written at configuration byte offset 0x94, chosen by `cfg_sock` (0 = socket A, 1 = socket B). Only bits 2:0 hold state. Bits 31:3 read as zero and ignore writes. Writes to any other offset change nothing, and reads of any other offset return zero.
- R2: After reset, socket A's number is 0, socket B's number is 1, and both index latches hold 0x00.
- R3: An I/O read or write is claimed (`io_claim` = 1) only when `io_addr[15:2]` equals `io_base[15:2]`. An unclaimed access asserts no `reg_sel` bit and returns 0x00 on `io_rdata`.
- R4: A write to base+0 loads the index latch of pair 0, and a write to base+2 loads the index latch of pair 1. The two latches are independent. A read of an index port returns its latch.
- R5: A data access at base+1 (pair 0) or base+3 (pair 1) selects socket s when bit 2 of s's number equals the pair, and bits 1:0 of s's number equal index[7:6] of that pair. `reg_sel[0]` selects socket A and `reg_sel[1]` selects socket B. `reg_offs` carries index[5:0].
- R6: A data read returns the selected socket's register byte. A data read that no socket owns returns 0xFF. A data write that no socket owns changes no register.
- R7: Data accesses leave the index latches unchanged, so repeated data accesses reach the same register.
- R8: `cfg_err` is 1 exactly when bit 2 of the two socket numbers differs.
- R9: When both sockets match the same data access, only socket A is selected.
- R10: `reg_we` is asserted only during a claimed I/O data write that some socket owns. `reg_sel` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_base | input | 16 | I/O base address; bits 1:0 are ignored |
| io_addr | input | 16 | I/O access address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| io_claim | output | 1 | Access falls in the four-port window |
| cfg_sock | input | 1 | Configuration target socket (0 = A, 1 = B) |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| cfg_err | output | 1 | Sockets are on different port pairs |
| reg_sel | output | 2 | One-hot socket register select |
| reg_we | output | 1 | Register write strobe |
| reg_offs | output | 6 | Register offset within the socket |
| reg_wdata | output | 8 | Register write data |
| reg_rdata_a | input | 8 | Socket A register read data |
| reg_rdata_b | input | 8 | Socket B register read data |

## Verification
The bench builds the block with its default parameters: reset numbers 0 and 1, and the 0x94 offset. The I/O base is moved at run time between 0x03E0 and 0x0100. The socket numbers are reprogrammed so that each socket lands on both port pairs and on several index quarters. This covers the pair-1 path, the mismatch flag, and the case where two sockets claim the same access. Unowned data accesses use indices whose top bits match neither socket, and the bench confirms that its register model stays unchanged.

// File: rtl/legacy_io_window.sv
module legacy_io_window #(
  parameter logic [2:0] SN_RST_A  = 3'd0,
  parameter logic [2:0] SN_RST_B  = 3'd1,
  parameter logic [7:0] SN_OFFSET = 8'h94
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_base,
  input  logic [15:0] io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        io_claim,
  input  logic        cfg_sock,
  input  logic [7:0]  cfg_addr,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_err,
  output logic [1:0]  reg_sel,
  output logic        reg_we,
  output logic [5:0]  reg_offs,
  output logic [7:0]  reg_wdata,
  input  logic [7:0]  reg_rdata_a,
  input  logic [7:0]  reg_rdata_b
);

  logic [1:0][2:0] sn_q;
  logic [1:0][7:0] idx_q;
  logic [1:0]      own;
  logic            pair, data_acc, sn_hit;
  logic [7:0]      cur_idx;

  assign io_claim = (io_rd | io_wr) && (io_addr[15:2] == io_base[15:2]);
  assign pair     = io_addr[1];
  assign data_acc = io_claim & io_addr[0];
  assign cur_idx  = idx_q[pair];
  assign sn_hit   = (cfg_addr == SN_OFFSET);

  for (genvar s = 0; s < 2; s++) begin : g_own
    assign own[s] = data_acc && (sn_q[s][2] == pair) && (sn_q[s][1:0] == cur_idx[7:6]);
  end

  assign reg_sel   = {own[1] & ~own[0], own[0]};
  assign reg_we    = io_wr & (|reg_sel);
  assign reg_offs  = cur_idx[5:0];
  assign reg_wdata = io_wdata;
  assign cfg_err   = sn_q[0][2] ^ sn_q[1][2];
  assign cfg_rdata = sn_hit ? {29'd0, sn_q[cfg_sock]} : 32'd0;

  always_comb begin
    if (!io_claim)       io_rdata = 8'h00;
    else if (!io_addr[0]) io_rdata = cur_idx;
    else if (reg_sel[0]) io_rdata = reg_rdata_a;
    else if (reg_sel[1]) io_rdata = reg_rdata_b;
    else                 io_rdata = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sn_q[0] <= SN_RST_A;
      sn_q[1] <= SN_RST_B;
      idx_q   <= '0;
    end else begin
      if (cfg_we && sn_hit) sn_q[cfg_sock] <= cfg_wdata[2:0];
      if (io_claim && io_wr && !io_addr[0]) idx_q[pair] <= io_wdata;
    end
  end

endmodule

module legacy_io_window_chk (
  input logic            clk,
  input logic            rst_n,
  input logic [15:0]     io_addr,
  input logic            io_rd,
  input logic            io_wr,
  input logic [7:0]      io_wdata,
  input logic [7:0]      io_rdata,
  input logic            io_claim,
  input logic            cfg_we,
  input logic [31:0]     cfg_rdata,
  input logic            cfg_err,
  input logic [1:0]      reg_sel,
  input logic            reg_we,
  input logic [1:0][7:0] idx_q
);

  logic idx_wr;
  assign idx_wr = io_claim && io_wr && !io_addr[0];

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:3] == 29'd0);

  assert_outside_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_claim |-> (reg_sel == 2'b00 && io_rdata == 8'h00));

  assert_idx0_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !io_addr[1]) |=> idx_q[0] == $past(io_wdata));

  assert_idx1_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && io_addr[1]) |=> idx_q[1] == $past(io_wdata));

  assert_unowned_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_claim && io_addr[0] && reg_sel == 2'b00) |-> io_rdata == 8'hFF);

  assert_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(idx_q));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_err) |-> $past(cfg_we));

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_sel));

  assert_we_qual_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (io_wr && io_claim && reg_sel != 2'b00));

endmodule

bind legacy_io_window legacy_io_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_claim(io_claim), .cfg_we(cfg_we),
  .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .reg_sel(reg_sel), .reg_we(reg_we),
  .idx_q(idx_q)
);

// File: tb/legacy_io_window_tb.sv
module legacy_io_window_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_base = 16'h03E0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_claim;
  logic        cfg_sock = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic [1:0]  reg_sel;
  logic        reg_we;
  logic [5:0]  reg_offs;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata_a, reg_rdata_b;
  logic [7:0]  mem_a [64];
  logic [7:0]  mem_b [64];
  int vecs = 0, errs = 0;
  logic [7:0]  rd8;
  logic        rdc;

  always #2.5 clk = ~clk;

  legacy_io_window u_dut (.*);

  assign reg_rdata_a = mem_a[reg_offs];
  assign reg_rdata_b = mem_b[reg_offs];

  always @(posedge clk)
    if (reg_we) begin
      if (reg_sel[0]) mem_a[reg_offs] <= reg_wdata;
      if (reg_sel[1]) mem_b[reg_offs] <= reg_wdata;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic c);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1; d = io_rdata; c = io_claim;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic cfg_write(input logic s, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); cfg_sock = s; cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic s, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); cfg_sock = s; cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    cfg_read(1'b0, 8'h94, v); chk("R2 socket A number", v, 32'd0);
    cfg_read(1'b1, 8'h94, v); chk("R2 socket B number", v, 32'd1);
    chk("R8 err at reset", cfg_err, 1'b0);
    io_read(16'h03E0, rd8, rdc); chk("R2 pair0 index", rd8, 8'h00);
    io_read(16'h03E2, rd8, rdc); chk("R2 pair1 index", rd8, 8'h00);
  endtask

  task automatic t_basic;
    io_write(16'h03E0, 8'h05);
    io_write(16'h03E1, 8'hA5);
    chk("R5 A write lands", mem_a[5], 8'hA5);
    io_read(16'h03E1, rd8, rdc); chk("R6 A read", rd8, 8'hA5);
    io_read(16'h03E1, rd8, rdc); chk("R7 index kept", rd8, 8'hA5);
    io_write(16'h03E0, 8'h45);
    io_write(16'h03E1, 8'h5A);
    chk("R5 B write lands", mem_b[5], 8'h5A);
    chk("R5 A untouched", mem_a[5], 8'hA5);
  endtask

  task automatic t_unowned;
    io_write(16'h03E0, 8'h85);
    io_read(16'h03E1, rd8, rdc); chk("R6 unowned read", rd8, 8'hFF);
    io_write(16'h03E1, 8'h11);
    chk("R6 unowned write A", mem_a[5], 8'hA5);
    chk("R6 unowned write B", mem_b[5], 8'h5A);
  endtask

  task automatic t_pair1;
    logic [31:0] v;
    cfg_write(1'b0, 8'h94, 32'hFFFF_FFFE);
    cfg_read(1'b0, 8'h94, v); chk("R1 reserved bits zero", v, 32'd6);
    chk("R8 err on mismatch", cfg_err, 1'b1);
    io_write(16'h03E2, 8'h83);
    io_write(16'h03E3, 8'h77);
    chk("R5 A on pair1", mem_a[3], 8'h77);
    io_write(16'h03E0, 8'h83);
    io_read(16'h03E1, rd8, rdc); chk("R5 pair0 no owner", rd8, 8'hFF);
    cfg_write(1'b1, 8'h94, 32'd5);
    chk("R8 err cleared", cfg_err, 1'b0);
    io_write(16'h03E2, 8'h47);
    io_write(16'h03E3, 8'h3C);
    chk("R5 B on pair1", mem_b[7], 8'h3C);
    io_read(16'h03E0, rd8, rdc); chk("R4 pair0 index", rd8, 8'h83);
    io_read(16'h03E2, rd8, rdc); chk("R4 pair1 index", rd8, 8'h47);
  endtask

  task automatic t_tie;
    cfg_write(1'b0, 8'h94, 32'd2);
    cfg_write(1'b1, 8'h94, 32'd2);
    io_write(16'h03E0, 8'h8A);
    io_write(16'h03E1, 8'h99);
    chk("R9 A wins", mem_a[10], 8'h99);
    chk("R9 B untouched", mem_b[10], 8'h8A);
    io_read(16'h03E1, rd8, rdc); chk("R9 read from A", rd8, 8'h99);
  endtask

  task automatic t_cfg_other;
    logic [31:0] v;
    cfg_write(1'b0, 8'h90, 32'd7);
    cfg_read(1'b0, 8'h94, v); chk("R1 other offset ignored", v, 32'd2);
    cfg_read(1'b0, 8'h90, v); chk("R1 other offset reads 0", v, 32'd0);
  endtask

  task automatic t_base;
    io_base = 16'h0100;
    io_read(16'h03E2, rd8, rdc);
    chk("R3 old base unclaimed", rdc, 1'b0);
    chk("R3 unclaimed data", rd8, 8'h00);
    io_read(16'h0102, rd8, rdc);
    chk("R3 new base claimed", rdc, 1'b1);
    chk("R4 index at new base", rd8, 8'h47);
    io_write(16'h03E1, 8'h00);
    chk("R3 outside write ignored", mem_a[10], 8'h99);
    io_base = 16'h03E0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_a[i] = 8'(i);
      mem_b[i] = 8'(i) | 8'h80;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_unowned();
    t_pair1();
    t_tie();
    t_cfg_other();
    t_base();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule